// File: doc/BRIEF.md
# Memory-to-Memory DMA Channel

This block is one DMA channel that copies a run of data items from a source region to a destination region. Each item goes through an internal holding register: the channel reads it from the source address and then writes it to the destination address. Software sets up the channel through a small register interface. That interface holds the control word, the source address, the destination address, the item count and a status word. Setting the run bit starts the channel.

The channel has two operating modes. In the software-started mode it moves items back to back until the count is exhausted, and it ignores the device request line. In the device-paced mode each item starts only while an external device holds its request line high. The device pauses the stream by dropping the request before the current item completes. An acknowledge pulse tells the device when the paced access is granted. A pacing-side bit selects which access is paced: the source read or the destination write.

Before each item the channel checks both addresses against the item width. A misaligned pair stops the channel with an error flag and issues no memory access. The memory port uses valid/ready signalling. `mem_req` is the valid signal and `mem_gnt` is the ready signal. A beat completes on a cycle where both are high. While `mem_req` is high and `mem_gnt` is low, the channel holds its address, direction, size and write data unchanged. For a read, the memory returns `mem_rdata` in the same cycle as the grant. The memory may withhold the grant for any number of cycles.

Top module: `dma_m2m_channel`

## Requirements
- R1: After reset, every register reads zero, and `mem_req` and `dev_ack` are low.
- R2: The register index on `cfg_addr`/`cfg_raddr` selects the register: 0 is control, 1 is source address, 2 is destination address, 3 is count, and 4 is status. Status bit 0 is the terminal flag and bit 1 is the alignment-error flag. Writing 1 to a status bit clears it. Writes to the source, destination and count registers are ignored while the run bit is set.
- R3: The control register fields are: bit 0 run, bits 2:1 mode, bits 4:3 width, bit 5 source step, bit 6 destination step, bit 7 pacing side, and bit 8 buffer enable. Mode 2'b10 is software-started. In this mode items are copied until the count reaches zero, and then the terminal flag sets and run clears. If run is set while the count is zero, the terminal flag sets and no access is made. `dev_req` has no effect in this mode, and `dev_ack` stays low.
- R4: Mode 2'b11 is device-paced. An item begins only if `dev_req` is high in the idle cycle before its read. Dropping `dev_req` by the grant cycle of an item's write stops the stream after that item. Raising it again resumes the stream.
- R5: Each item is a source read (`mem_we`=0) followed by a destination write (`mem_we`=1). The write carries the data returned by the read. `mem_size` gives the width: 0 is 8 bits, 1 is 16 bits, 2 is 32 bits.
- R6: The width field selects the item width: 0 is 8 bits, 1 is 16 bits, and 2 or 3 is 32 bits. If either address is not a multiple of the item width when an item would begin, the channel sets the alignment-error flag, clears run and issues no memory request.
- R7: After each item, the source and destination addresses each advance by the item size in bytes (1, 2 or 4) if their step bit is set. If the step bit is clear, that address stays fixed.
- R8: In paced mode, `dev_ack` is high in the grant cycle of the source read when the pacing-side bit is 1. When the bit is 0, it is high in the grant cycle of the destination write instead. It is never high in any other cycle.
- R9: While `mem_req` is high and `mem_gnt` is low, `mem_addr`, `mem_we`, `mem_size` and `mem_wdata` hold their values into the next cycle.
- R10: The buffer-enable bit is stored and reads back. It does not change the read-then-write order or the number of accesses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index for writes |
| cfg_wdata | input | 32 | Register write data |
| cfg_raddr | input | 3 | Register index for reads |
| cfg_rdata | output | 32 | Read data for the register at `cfg_raddr` (combinational) |
| mem_req | output | 1 | Memory access valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW (32) | Byte address of the access |
| mem_size | output | 2 | Access width code |
| mem_wdata | output | DW (32) | Write data, in the low lanes |
| mem_gnt | input | 1 | Memory ready; completes the beat |
| mem_rdata | input | DW (32) | Read data, valid in the grant cycle |
| dev_req | input | 1 | Device pacing request |
| dev_ack | output | 1 | Paced access granted |

## Verification
The assertions assume that software leaves the control register alone while a read or write beat is outstanding. A control write in that window could change the width or direction under a pending request, and the hold check would then fail for reasons outside the channel. They also assume that `mem_rdata` is valid in every cycle where `mem_gnt` meets a read. The bench writes control only when the channel is idle or stalled on a low `dev_req`. Its memory model drives `mem_rdata` and `mem_gnt` together on the falling edge and can withhold the grant every other cycle to exercise back-pressure.

// File: rtl/dma_pkg.sv
`timescale 1ns/1ps
package dma_pkg;
  localparam int REG_W = 32;
  localparam int IDX_W = 3;

  localparam logic [IDX_W-1:0] IDX_CTRL = 3'd0;
  localparam logic [IDX_W-1:0] IDX_SRC  = 3'd1;
  localparam logic [IDX_W-1:0] IDX_DST  = 3'd2;
  localparam logic [IDX_W-1:0] IDX_CNT  = 3'd3;
  localparam logic [IDX_W-1:0] IDX_STAT = 3'd4;

  localparam logic [1:0] MODE_SW    = 2'b10;
  localparam logic [1:0] MODE_PACED = 2'b11;

  typedef enum logic [1:0] {WID_8 = 2'd0, WID_16 = 2'd1, WID_32 = 2'd2, WID_32B = 2'd3} width_e;

  typedef struct packed {
    logic   buf_en;
    logic   pace_src;
    logic   dst_step;
    logic   src_step;
    width_e width;
    logic [1:0] mode;
    logic   run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} eng_state_e;

  function automatic logic [2:0] step_bytes(width_e w);
    case (w)
      WID_8:   return 3'd1;
      WID_16:  return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [1:0] size_code(width_e w);
    case (w)
      WID_8:   return 2'd0;
      WID_16:  return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

  function automatic logic is_aligned(logic [1:0] lo, width_e w);
    case (w)
      WID_8:   return 1'b1;
      WID_16:  return ~lo[0];
      default: return (lo == 2'b00);
    endcase
  endfunction
endpackage

// File: rtl/dma_chan_regs.sv
`timescale 1ns/1ps
module dma_chan_regs
  import dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic [IDX_W-1:0]    cfg_addr,
  input  logic [REG_W-1:0]    cfg_wdata,
  input  logic [IDX_W-1:0]    cfg_raddr,
  output logic [REG_W-1:0]    cfg_rdata,
  input  logic                xfer_done,
  input  logic                align_err,
  output ctrl_t               ctrl,
  output logic [AW-1:0]       src_addr,
  output logic [AW-1:0]       dst_addr,
  output logic [CW-1:0]       count
);
  logic tc_q, err_q;
  logic [AW-1:0] src_step_v, dst_step_v;

  assign src_step_v = ctrl.src_step ? AW'(step_bytes(ctrl.width)) : '0;
  assign dst_step_v = ctrl.dst_step ? AW'(step_bytes(ctrl.width)) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl     <= '0;
      src_addr <= '0;
      dst_addr <= '0;
      count    <= '0;
      tc_q     <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (cfg_wr) begin
        case (cfg_addr)
          IDX_CTRL: ctrl <= ctrl_t'(cfg_wdata[CTRL_W-1:0]);
          IDX_SRC:  if (!ctrl.run) src_addr <= cfg_wdata[AW-1:0];
          IDX_DST:  if (!ctrl.run) dst_addr <= cfg_wdata[AW-1:0];
          IDX_CNT:  if (!ctrl.run) count <= cfg_wdata[CW-1:0];
          IDX_STAT: begin
            tc_q  <= tc_q & ~cfg_wdata[0];
            err_q <= err_q & ~cfg_wdata[1];
          end
          default: ;
        endcase
      end
      if (xfer_done) begin
        src_addr <= src_addr + src_step_v;
        dst_addr <= dst_addr + dst_step_v;
        count    <= count - 1'b1;
      end
      if (align_err) begin
        err_q    <= 1'b1;
        ctrl.run <= 1'b0;
      end
      if (ctrl.run && count == '0) begin
        tc_q     <= 1'b1;
        ctrl.run <= 1'b0;
      end
    end
  end

  always_comb begin
    case (cfg_raddr)
      IDX_CTRL: cfg_rdata = REG_W'(ctrl);
      IDX_SRC:  cfg_rdata = REG_W'(src_addr);
      IDX_DST:  cfg_rdata = REG_W'(dst_addr);
      IDX_CNT:  cfg_rdata = REG_W'(count);
      IDX_STAT: cfg_rdata = REG_W'({err_q, tc_q});
      default:  cfg_rdata = '0;
    endcase
  end

  // R3: the terminal flag never rises while the channel remains running
  p_tc_stops_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tc_q) |-> !ctrl.run);

  // R2: while running and no item completes, the addresses cannot be rewritten
  p_addr_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.run && !xfer_done) |=> ($stable(src_addr) && $stable(dst_addr)));

  // R6: an alignment error always leaves the error flag set and run clear
  p_err_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |=> (err_q && !ctrl.run));
endmodule

// File: rtl/dma_xfer_engine.sv
`timescale 1ns/1ps
module dma_xfer_engine
  import dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic [1:0]     mode,
  input  width_e         width,
  input  logic           pace_src,
  input  logic [AW-1:0]  src_addr,
  input  logic [AW-1:0]  dst_addr,
  input  logic [CW-1:0]  count,
  input  logic           dev_req,
  input  logic           mem_gnt,
  input  logic [DW-1:0]  mem_rdata,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [1:0]     mem_size,
  output logic [DW-1:0]  mem_wdata,
  output logic           dev_ack,
  output logic           xfer_done,
  output logic           align_err
);
  eng_state_e state, state_nx;
  logic [DW-1:0] hold_q;
  logic paced, runnable, addr_ok, eligible, launch;

  assign paced    = (mode == MODE_PACED);
  assign runnable = paced || (mode == MODE_SW);
  assign addr_ok  = is_aligned(src_addr[1:0], width) && is_aligned(dst_addr[1:0], width);
  assign eligible = (state == ST_IDLE) && run && (count != '0) && runnable;
  assign align_err = eligible && !addr_ok;
  assign launch    = eligible && addr_ok && (!paced || dev_req);

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:  if (launch) state_nx = ST_READ;
      ST_READ:  if (mem_gnt) state_nx = ST_WRITE;
      ST_WRITE: if (mem_gnt) state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      hold_q <= '0;
    end else begin
      state <= state_nx;
      if (state == ST_READ && mem_gnt) hold_q <= mem_rdata;
    end
  end

  assign mem_req   = (state != ST_IDLE);
  assign mem_we    = (state == ST_WRITE);
  assign mem_addr  = (state == ST_WRITE) ? dst_addr : src_addr;
  assign mem_size  = size_code(width);
  assign mem_wdata = hold_q;
  assign xfer_done = (state == ST_WRITE) && mem_gnt;
  assign dev_ack   = paced && mem_gnt &&
                     (pace_src ? (state == ST_READ) : (state == ST_WRITE));

  // R9: a pending beat keeps its attributes until granted
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_size) && $stable(mem_wdata)));

  // R5: a granted read is followed by a write of the returned data
  p_read_then_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_gnt) |=> (mem_req && mem_we && mem_wdata == $past(mem_rdata)));

  // R4: a paced item starts only after the request was seen high in idle
  p_paced_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_READ && $past(state) == ST_IDLE && paced) |-> $past(dev_req));

  // R6: every memory request carries an address aligned to the width
  p_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> is_aligned(mem_addr[1:0], width));
endmodule

// File: rtl/dma_m2m_channel.sv
`timescale 1ns/1ps
module dma_m2m_channel
  import dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic [2:0]        cfg_raddr,
  output logic [31:0]       cfg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [1:0]        mem_size,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_gnt,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              dev_req,
  output logic              dev_ack
);
  ctrl_t          ctrl;
  logic [AW-1:0]  src_addr, dst_addr;
  logic [CW-1:0]  count;
  logic           xfer_done, align_err;

  dma_chan_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_raddr (cfg_raddr),
    .cfg_rdata (cfg_rdata),
    .xfer_done (xfer_done),
    .align_err (align_err),
    .ctrl      (ctrl),
    .src_addr  (src_addr),
    .dst_addr  (dst_addr),
    .count     (count)
  );

  dma_xfer_engine #(.AW(AW), .DW(DW), .CW(CW)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (ctrl.run),
    .mode      (ctrl.mode),
    .width     (ctrl.width),
    .pace_src  (ctrl.pace_src),
    .src_addr  (src_addr),
    .dst_addr  (dst_addr),
    .count     (count),
    .dev_req   (dev_req),
    .mem_gnt   (mem_gnt),
    .mem_rdata (mem_rdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_size  (mem_size),
    .mem_wdata (mem_wdata),
    .dev_ack   (dev_ack),
    .xfer_done (xfer_done),
    .align_err (align_err)
  );

  // R3: no source read is ever issued with the count exhausted
  p_no_read_at_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (count != '0));

  // R8: in software-started mode the device never sees an acknowledge
  p_sw_no_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.mode == MODE_SW) |-> !dev_ack);
endmodule

// File: tb/tb_dma_m2m_channel.sv
`timescale 1ns/1ps
module tb_dma_m2m_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [2:0]  cfg_raddr = '0;
  logic [31:0] cfg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [1:0]  mem_size;
  logic [31:0] mem_wdata;
  logic        mem_gnt = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        dev_req = 1'b0;
  logic        dev_ack;

  int n_chk = 0, n_fail = 0;
  int n_rd = 0, n_wr = 0, ack_rd = 0, ack_wr = 0, hold_viol = 0;
  logic [1:0] last_size = '0;
  logic stall_en = 1'b0, stall_tog = 1'b0;
  logic pend = 1'b0, pend_we = 1'b0;
  logic [31:0] pend_addr = '0;
  logic [7:0] mem_m [256];
  bit finished = 0;

  dma_m2m_channel dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .dev_req(dev_req), .dev_ack(dev_ack)
  );

  always #2 clk = ~clk;

  function automatic logic [7:0] orig(int a);
    return 8'(a) ^ 8'h5A;
  endfunction

  function automatic logic [31:0] mk_ctrl(bit run, logic [1:0] mode, logic [1:0] wid,
                                          bit si, bit di, bit ps, bit be);
    return {23'b0, be, ps, di, si, wid, mode, run};
  endfunction

  // memory model and monitor, acting on the falling edge
  initial begin
    for (int i = 0; i < 256; i++) mem_m[i] = orig(i);
    forever begin
      @(negedge clk);
      if (mem_req) begin
        mem_gnt = !(stall_en && !stall_tog);
        stall_tog = ~stall_tog;
      end else mem_gnt = 1'b0;
      case (mem_size)
        2'd0:    mem_rdata = {24'b0, mem_m[mem_addr[7:0]]};
        2'd1:    mem_rdata = {16'b0, mem_m[mem_addr[7:0]+8'd1], mem_m[mem_addr[7:0]]};
        default: mem_rdata = {mem_m[mem_addr[7:0]+8'd3], mem_m[mem_addr[7:0]+8'd2],
                              mem_m[mem_addr[7:0]+8'd1], mem_m[mem_addr[7:0]]};
      endcase
      #1;
      if (pend && mem_req && (mem_addr != pend_addr || mem_we != pend_we)) hold_viol++;
      pend = mem_req && !mem_gnt;
      pend_addr = mem_addr;
      pend_we = mem_we;
      if (mem_req && mem_gnt) begin
        last_size = mem_size;
        if (mem_we) begin
          n_wr++;
          if (dev_ack) ack_wr++;
          mem_m[mem_addr[7:0]] = mem_wdata[7:0];
          if (mem_size >= 2'd1) mem_m[mem_addr[7:0]+8'd1] = mem_wdata[15:8];
          if (mem_size >= 2'd2) begin
            mem_m[mem_addr[7:0]+8'd2] = mem_wdata[23:16];
            mem_m[mem_addr[7:0]+8'd3] = mem_wdata[31:24];
          end
        end else begin
          n_rd++;
          if (dev_ack) ack_rd++;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    cfg_raddr = a;
    #1 v = cfg_rdata;
  endtask

  task automatic clr_mon();
    n_rd = 0; n_wr = 0; ack_rd = 0; ack_wr = 0; hold_viol = 0;
  endtask

  task automatic wait_done();
    logic [31:0] v;
    for (int i = 0; i < 400; i++) begin
      rd(3'd0, v);
      if (v[0] == 1'b0) break;
    end
  endtask

  task automatic setup(input int s, input int d, input int c);
    wr(3'd1, s); wr(3'd2, d); wr(3'd3, c); wr(3'd4, 32'h3);
    clr_mon();
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int i = 0; i < 5; i++) begin
      rd(3'(i), v);
      chk($sformatf("R1 reg %0d after reset", i), v, 0);
    end
    chk("R1 mem_req low", {31'b0, mem_req}, 0);
    chk("R1 dev_ack low", {31'b0, dev_ack}, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(3'd1, 32'h1234_5678); rd(3'd1, v); chk("R2 source readback", v, 32'h1234_5678);
    wr(3'd2, 32'h0000_00C4); rd(3'd2, v); chk("R2 dest readback", v, 32'h0000_00C4);
    wr(3'd3, 32'h0000_ABCD); rd(3'd3, v); chk("R2 count readback", v, 32'h0000_ABCD);
    wr(3'd0, mk_ctrl(0, 2'b10, 2'd2, 1, 0, 1, 1)); rd(3'd0, v);
    chk("R10 buffer-enable stored", v, mk_ctrl(0, 2'b10, 2'd2, 1, 0, 1, 1));
    wr(3'd0, 0);
  endtask

  task automatic t_sw_word();
    logic [31:0] v;
    setup(32'h10, 32'h80, 4);
    wr(3'd0, mk_ctrl(1, 2'b10, 2'd2, 1, 1, 0, 1));
    wait_done();
    chk("R3 reads for count 4", n_rd, 4);
    chk("R10 writes equal reads with buffer on", n_wr, 4);
    for (int k = 0; k < 16; k++)
      chk($sformatf("R5 word copy byte %0d", k), {24'b0, mem_m[8'h80 + k]}, {24'b0, orig(16 + k)});
    rd(3'd4, v); chk("R3 terminal flag", v, 1);
    rd(3'd3, v); chk("R3 count zero", v, 0);
    rd(3'd1, v); chk("R7 source stepped by 4", v, 32'h20);
    rd(3'd2, v); chk("R7 dest stepped by 4", v, 32'h90);
    chk("R5 size code word", {30'b0, last_size}, 2);
    wr(3'd4, 1); rd(3'd4, v); chk("R2 write-1 clears terminal", v, 0);
  endtask

  task automatic t_byte_fixed();
    logic [31:0] v;
    setup(32'h30, 32'hC0, 3);
    wr(3'd0, mk_ctrl(1, 2'b10, 2'd0, 1, 0, 0, 0));
    wait_done();
    chk("R7 fixed dest holds last byte", {24'b0, mem_m[8'hC0]}, {24'b0, orig(8'h32)});
    chk("R5 byte write leaves next lane", {24'b0, mem_m[8'hC1]}, {24'b0, orig(8'hC1)});
    rd(3'd1, v); chk("R7 source stepped by 1", v, 32'h33);
    rd(3'd2, v); chk("R7 dest fixed", v, 32'hC0);
    chk("R5 size code byte", {30'b0, last_size}, 0);
    chk("R10 writes with buffer off", n_wr, 3);
  endtask

  task automatic t_half_stall();
    logic [31:0] v;
    setup(32'h40, 32'hA0, 2);
    stall_en = 1'b1;
    wr(3'd0, mk_ctrl(1, 2'b10, 2'd1, 1, 1, 0, 0));
    wait_done();
    stall_en = 1'b0;
    for (int k = 0; k < 4; k++)
      chk($sformatf("R5 halfword copy byte %0d", k), {24'b0, mem_m[8'hA0 + k]}, {24'b0, orig(8'h40 + k)});
    chk("R9 held beats unchanged", hold_viol, 0);
    chk("R5 size code half", {30'b0, last_size}, 1);
    rd(3'd1, v); chk("R7 source stepped by 2", v, 32'h44);
    rd(3'd2, v); chk("R7 dest stepped by 2", v, 32'hA4);
  endtask

  task automatic t_align();
    logic [31:0] v;
    setup(32'h12, 32'h80, 2);
    wr(3'd0, mk_ctrl(1, 2'b10, 2'd2, 1, 1, 0, 0));
    repeat (4) @(negedge clk);
    rd(3'd4, v); chk("R6 source misaligned error", v, 2);
    rd(3'd0, v); chk("R6 run cleared", {31'b0, v[0]}, 0);
    rd(3'd3, v); chk("R6 count untouched", v, 2);
    chk("R6 no access", n_rd + n_wr, 0);
    setup(32'h40, 32'h41, 1);
    wr(3'd0, mk_ctrl(1, 2'b10, 2'd1, 1, 1, 0, 0));
    repeat (4) @(negedge clk);
    rd(3'd4, v); chk("R6 dest misaligned half error", v, 2);
    chk("R6 no access half", n_rd + n_wr, 0);
    wr(3'd4, 2); rd(3'd4, v); chk("R2 write-1 clears error", v, 0);
  endtask

  task automatic t_zero();
    logic [31:0] v;
    setup(32'h0, 32'hF0, 0);
    wr(3'd0, mk_ctrl(1, 2'b10, 2'd2, 1, 1, 0, 0));
    repeat (4) @(negedge clk);
    rd(3'd4, v); chk("R3 zero count terminal", v, 1);
    chk("R3 zero count no access", n_rd + n_wr, 0);
  endtask

  task automatic t_paced_src();
    logic [31:0] v;
    setup(32'h50, 32'hD0, 3);
    dev_req = 1'b0;
    wr(3'd0, mk_ctrl(1, 2'b11, 2'd2, 1, 1, 1, 0));
    repeat (8) @(negedge clk);
    chk("R4 no start without request", n_rd, 0);
    rd(3'd0, v); chk("R4 still running", {31'b0, v[0]}, 1);
    wr(3'd1, 32'h70); rd(3'd1, v); chk("R2 source locked while running", v, 32'h50);
    @(negedge clk);
    dev_req = 1'b1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      #1.5;
      if (n_wr >= 1) break;
    end
    dev_req = 1'b0;
    repeat (8) @(negedge clk);
    chk("R4 paused after one item", n_wr, 1);
    rd(3'd3, v); chk("R4 count after pause", v, 2);
    chk("R8 one read ack", ack_rd, 1);
    @(negedge clk);
    dev_req = 1'b1;
    wait_done();
    dev_req = 1'b0;
    chk("R4 resumed to completion", n_wr, 3);
    chk("R8 acks on reads", ack_rd, 3);
    chk("R8 no acks on writes", ack_wr, 0);
    for (int k = 0; k < 12; k++)
      chk($sformatf("R5 paced copy byte %0d", k), {24'b0, mem_m[8'hD0 + k]}, {24'b0, orig(8'h50 + k)});
    rd(3'd4, v); chk("R3 paced terminal", v, 1);
  endtask

  task automatic t_paced_dst();
    setup(32'h60, 32'hE0, 2);
    dev_req = 1'b1;
    wr(3'd0, mk_ctrl(1, 2'b11, 2'd2, 1, 1, 0, 0));
    wait_done();
    dev_req = 1'b0;
    chk("R8 acks on writes", ack_wr, 2);
    chk("R8 no acks on reads", ack_rd, 0);
  endtask

  task automatic t_sw_ignores_req();
    setup(32'h00, 32'hF0, 1);
    dev_req = 1'b1;
    wr(3'd0, mk_ctrl(1, 2'b10, 2'd2, 1, 1, 1, 0));
    wait_done();
    dev_req = 1'b0;
    chk("R3 software mode item done", n_wr, 1);
    chk("R3 no ack in software mode", ack_rd + ack_wr, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_sw_word();
    t_byte_fixed();
    t_half_stall();
    t_align();
    t_zero();
    t_paced_src();
    t_paced_dst();
    t_sw_ignores_req();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule